// File: doc/BRIEF.md
# Hidden Command Sequence Detector for a Nonvolatile SRAM

This block watches the control strobes and address lines of an asynchronous SRAM bus and recognizes a command that is hidden inside ordinary read traffic. A host issues six reads in a fixed address order. The first five addresses form a shared prefix. The sixth address decides whether the block requests a save of the array into nonvolatile cells or a reload from those cells. Reads look normal on the bus, so no extra pin is needed to issue either command.

The chip enable, output enable and write enable inputs are brought into the system clock through two-flop synchronizers. The address is delayed by the same two stages so that it lines up with them. A read counts when the read select (both enables low) ends with the write enable held high. The address is taken at that moment. When the command is recognized, the block pulses a request for one cycle. It then holds `busy` high for a fixed number of cycles, one count for saving and one for reloading. The surrounding memory uses `busy` to block accesses and to float its data bus. All control and status pins are plain levels or pulses: the block has no streaming interface, so no back-pressure rules apply.

Top module: `nv_cmd_seq_det`

## Requirements
- R1: After reset, `store_req`, `recall_req` and `busy` are all low.
- R2: Six completed reads at 19'h24A1B, 19'h5B3C4, 19'h13D7E, 19'h6A082, 19'h0F5C9 and then 19'h7E1F0, in that order, give exactly one single-cycle pulse on `store_req`. These are the default addresses.
- R3: The same five-address prefix followed by 19'h30E6D gives exactly one single-cycle pulse on `recall_req`.
- R4: A read completes when the chip enable goes high while the output enable is low, or when the output enable goes high while the chip enable is low. Both forms count, and they may be mixed within one sequence.
- R5: A read whose address does not match the expected step returns the matcher to step zero. If that address equals the first prefix address, the matcher moves to step one instead.
- R6: A write (chip enable and write enable both low) anywhere in the sequence cancels it, so the remaining reads give no command.
- R7: When a write begins in the same cycle that the sixth read completes, the write wins and no command is issued.
- R8: `busy` rises in the same cycle as a request pulse. It stays high for STORE_CYC cycles after a store and RECALL_CYC cycles after a recall, and it never rises without a request.
- R9: Reads that complete while `busy` is high are ignored and leave the matcher at step zero. Neither a full sequence nor a partial one made during `busy` leads to a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_ce_n | input | 1 | Bus chip enable, active low, asynchronous |
| mem_oe_n | input | 1 | Bus output enable, active low, asynchronous |
| mem_we_n | input | 1 | Bus write enable, active low, asynchronous |
| mem_addr | input | ADDR_W | Bus address, asynchronous, stable around each strobe |
| store_req | output | 1 | One-cycle request to save the array into nonvolatile cells |
| recall_req | output | 1 | One-cycle request to reload the array from nonvolatile cells |
| busy | output | 1 | Command in progress; accesses blocked and data bus floated |

## Verification
The sixth read completing and a write starting can land in the same clock cycle. This happens when the output enable rises and the write enable falls at the same instant while the chip enable stays low. The bench provokes exactly that and expects nothing in the scoreboard. Any request pulse then counts as a mismatch. A full store sequence follows right after, and it must give one clean request, which shows the matcher was left at step zero rather than part-way through.

// File: rtl/nv_cmd_pkg.sv
package nv_cmd_pkg;
  localparam int unsigned SEQ_PREFIX = 5;
  localparam int unsigned STEP_W = $clog2(SEQ_PREFIX + 1);

  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_STORE  = 2'd1,
    CMD_RECALL = 2'd2
  } nv_cmd_e;
endpackage

// File: rtl/nv_cmd_sync.sv
module nv_cmd_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stable;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta   <= 1'b1;
        stable <= 1'b1;
      end else begin
        meta   <= d[i];
        stable <= meta;
      end
    end
    assign q[i] = stable;
  end
endmodule

// File: rtl/nv_cmd_access.sv
module nv_cmd_access (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_s,
  input  logic oe_s,
  input  logic we_s,
  output logic rd_done,
  output logic wr_start
);
  logic sel, wr_act;
  logic sel_q, wr_q, we_q;

  assign sel    = ~ce_s & ~oe_s;
  assign wr_act = ~ce_s & ~we_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
      we_q  <= 1'b1;
    end else begin
      sel_q <= sel;
      wr_q  <= wr_act;
      we_q  <= we_s;
    end
  end

  // read select ends with write enable inactive during the access
  assign rd_done  = sel_q & ~sel & we_q;
  assign wr_start = wr_act & ~wr_q;
endmodule

// File: rtl/nv_cmd_matcher.sv
module nv_cmd_matcher import nv_cmd_pkg::*; #(
  parameter int unsigned ADDR_W = 19,
  parameter logic [SEQ_PREFIX-1:0][ADDR_W-1:0] SEQ_ADDR = '0,
  parameter logic [ADDR_W-1:0] STORE_ADDR  = '0,
  parameter logic [ADDR_W-1:0] RECALL_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_done,
  input  logic              wr_start,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  output nv_cmd_e           fire
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(SEQ_PREFIX);

  logic [STEP_W-1:0] step, step_nx;
  logic              hit_first;

  assign hit_first = (addr == SEQ_ADDR[0]);

  always_comb begin
    step_nx = step;
    fire    = CMD_IDLE;
    if (wr_start) begin
      step_nx = '0;
    end else if (rd_done) begin
      if (busy) begin
        step_nx = '0;
      end else if (step == LAST) begin
        if (addr == STORE_ADDR) begin
          fire    = CMD_STORE;
          step_nx = '0;
        end else if (addr == RECALL_ADDR) begin
          fire    = CMD_RECALL;
          step_nx = '0;
        end else begin
          step_nx = hit_first ? STEP_W'(1) : '0;
        end
      end else if (addr == SEQ_ADDR[step]) begin
        step_nx = step + STEP_W'(1);
      end else begin
        step_nx = hit_first ? STEP_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= '0;
    else        step <= step_nx;
  end
endmodule

// File: rtl/nv_cmd_busy_timer.sv
module nv_cmd_busy_timer import nv_cmd_pkg::*; #(
  parameter int unsigned STORE_CYC  = 1250000,
  parameter int unsigned RECALL_CYC = 5000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  nv_cmd_e start,
  output logic    busy
);
  localparam int unsigned MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start == CMD_STORE) begin
      busy   <= 1'b1;
      remain <= CNT_W'(STORE_CYC - 1);
    end else if (start == CMD_RECALL) begin
      busy   <= 1'b1;
      remain <= CNT_W'(RECALL_CYC - 1);
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - CNT_W'(1);
    end
  end
endmodule

// File: rtl/nv_cmd_seq_det.sv
module nv_cmd_seq_det import nv_cmd_pkg::*; #(
  parameter int unsigned ADDR_W = 19,
  parameter logic [SEQ_PREFIX-1:0][ADDR_W-1:0] SEQ_ADDR =
    {19'h0F5C9, 19'h6A082, 19'h13D7E, 19'h5B3C4, 19'h24A1B},
  parameter logic [ADDR_W-1:0] STORE_ADDR  = 19'h7E1F0,
  parameter logic [ADDR_W-1:0] RECALL_ADDR = 19'h30E6D,
  parameter int unsigned STORE_CYC  = 1250000,
  parameter int unsigned RECALL_CYC = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_ce_n,
  input  logic              mem_oe_n,
  input  logic              mem_we_n,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              store_req,
  output logic              recall_req,
  output logic              busy
);
  logic [2:0]        strb_s;
  logic [ADDR_W-1:0] addr_d1, addr_d2;
  logic              rd_done, wr_start;
  nv_cmd_e           fire;

  nv_cmd_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({mem_we_n, mem_oe_n, mem_ce_n}),
    .q(strb_s)
  );

  // address delayed to line up with the synchronized strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_d1 <= '0;
      addr_d2 <= '0;
    end else begin
      addr_d1 <= mem_addr;
      addr_d2 <= addr_d1;
    end
  end

  nv_cmd_access u_access (
    .clk(clk), .rst_n(rst_n),
    .ce_s(strb_s[0]), .oe_s(strb_s[1]), .we_s(strb_s[2]),
    .rd_done(rd_done), .wr_start(wr_start)
  );

  nv_cmd_matcher #(
    .ADDR_W(ADDR_W), .SEQ_ADDR(SEQ_ADDR),
    .STORE_ADDR(STORE_ADDR), .RECALL_ADDR(RECALL_ADDR)
  ) u_matcher (
    .clk(clk), .rst_n(rst_n),
    .rd_done(rd_done), .wr_start(wr_start), .busy(busy),
    .addr(addr_d2), .fire(fire)
  );

  nv_cmd_busy_timer #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(fire), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      store_req  <= (fire == CMD_STORE);
      recall_req <= (fire == CMD_RECALL);
    end
  end
endmodule

// File: rtl/nv_cmd_seq_det_chk.sv
module nv_cmd_seq_det_chk #(
  parameter int unsigned STORE_CYC  = 1250000,
  parameter int unsigned RECALL_CYC = 5000
) (
  input logic clk,
  input logic rst_n,
  input logic store_req,
  input logic recall_req,
  input logic busy
);
  int busy_len, want_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_len <= 0;
      want_len <= 0;
    end else if (store_req) begin
      busy_len <= 1;
      want_len <= int'(STORE_CYC);
    end else if (recall_req) begin
      busy_len <= 1;
      want_len <= int'(RECALL_CYC);
    end else if (busy) begin
      busy_len <= busy_len + 1;
    end
  end

  AST_ONE_CMD_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({store_req, recall_req})); // R2
  AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) store_req |=> !store_req); // R2
  AST_RECALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) recall_req |=> !recall_req); // R3
  AST_BUSY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n) (store_req || recall_req) |-> busy); // R8
  AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> (store_req || recall_req)); // R8
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (busy_len == want_len)); // R8
  AST_NO_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (store_req || recall_req) |-> !$past(busy)); // R9
endmodule

bind nv_cmd_seq_det nv_cmd_seq_det_chk #(
  .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .store_req(store_req), .recall_req(recall_req), .busy(busy)
);

// File: tb/test_nv_cmd_seq_det.sv
module test_nv_cmd_seq_det;
  localparam int ST_CYC = 300;
  localparam int RC_CYC = 60;
  localparam logic [18:0] P0 = 19'h24A1B, P1 = 19'h5B3C4, P2 = 19'h13D7E,
                          P3 = 19'h6A082, P4 = 19'h0F5C9;
  localparam logic [18:0] S6 = 19'h7E1F0, R6 = 19'h30E6D, XX = 19'h11111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [18:0] addr = '0;
  logic store_req, recall_req, busy;

  always #5 clk = ~clk;

  nv_cmd_seq_det #(.STORE_CYC(ST_CYC), .RECALL_CYC(RC_CYC)) i_nv_cmd_seq_det (
    .clk(clk), .rst_n(rst_n),
    .mem_ce_n(ce_n), .mem_oe_n(oe_n), .mem_we_n(we_n), .mem_addr(addr),
    .store_req(store_req), .recall_req(recall_req), .busy(busy)
  );

  int n_cmp = 0, n_bad = 0;
  int exp_kind[$];
  string exp_tag[$];
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: 1 = store, 2 = recall
  int meas = 0, want = 0;
  bit measuring = 1'b0;
  string cur_tag = "";
  always @(negedge clk) begin
    if (rst_n) begin
      if (store_req || recall_req) begin
        int kind;
        kind = (store_req && recall_req) ? 3 : (store_req ? 1 : 2);
        if (exp_kind.size() == 0) begin
          chk(1'b0, "R5/R6/R7/R9", "unexpected command", kind, 0);
          cur_tag = "R8";
          want = (kind == 1) ? ST_CYC : RC_CYC;
        end else begin
          int e;
          e = exp_kind.pop_front();
          cur_tag = exp_tag.pop_front();
          chk(kind == e, cur_tag, "command kind", kind, e);
          want = (e == 1) ? ST_CYC : RC_CYC;
        end
        chk(busy == 1'b1, "R8", "busy with request", int'(busy), 1);
        measuring = 1'b1;
        meas = 0;
      end
      if (measuring) begin
        if (busy) meas++;
        else begin
          chk(meas == want, "R8", "busy length", meas, want);
          measuring = 1'b0;
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // oe_mode=1: output-enable delimits the access; 0: chip-enable delimits
  task automatic rd(input logic [18:0] a, input bit oe_mode);
    addr = a;
    idle(2);
    if (oe_mode) begin
      ce_n = 1'b0; idle(2);
      oe_n = 1'b0; idle(4);
      oe_n = 1'b1; idle(4);
      ce_n = 1'b1;
    end else begin
      oe_n = 1'b0; idle(2);
      ce_n = 1'b0; idle(4);
      ce_n = 1'b1; idle(4);
      oe_n = 1'b1;
    end
    idle(2);
  endtask

  task automatic wr(input logic [18:0] a);
    addr = a;
    idle(2);
    ce_n = 1'b0; we_n = 1'b0; idle(4);
    we_n = 1'b1; ce_n = 1'b1; idle(3);
  endtask

  task automatic prefix(input bit [4:0] modes);
    rd(P0, modes[0]); rd(P1, modes[1]); rd(P2, modes[2]);
    rd(P3, modes[3]); rd(P4, modes[4]);
  endtask

  task automatic expect_cmd(input int kind, input string tag);
    exp_kind.push_back(kind);
    exp_tag.push_back(tag);
  endtask

  task automatic settle(input string tag);
    idle(8);
    while (busy) @(negedge clk);
    idle(6);
    chk(exp_kind.size() == 0, tag, "outstanding expected commands", exp_kind.size(), 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk(store_req == 1'b0, "R1", "store_req after reset", int'(store_req), 0);
    chk(recall_req == 1'b0, "R1", "recall_req after reset", int'(recall_req), 0);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);

    // R2: chip-enable strobes, store
    prefix(5'b00000); expect_cmd(1, "R2"); rd(S6, 1'b0); settle("R2");
    // R3/R4: output-enable strobes, recall
    prefix(5'b11111); expect_cmd(2, "R3"); rd(R6, 1'b1); settle("R3");
    // R4: mixed strobe forms
    prefix(5'b01010); expect_cmd(2, "R4"); rd(R6, 1'b0); settle("R4");
    // R5: repeat of first address restarts at step one
    rd(P0, 1'b0); rd(P1, 1'b0); prefix(5'b00000); expect_cmd(1, "R5"); rd(S6, 1'b0); settle("R5");
    // R5: stray address in the middle
    rd(P0, 1'b0); rd(P1, 1'b0); rd(XX, 1'b0); rd(P2, 1'b0); rd(P3, 1'b0); rd(P4, 1'b0);
    rd(S6, 1'b0); settle("R5");
    // R5: wrong sixth address
    prefix(5'b00000); rd(P2, 1'b0); rd(S6, 1'b0); settle("R5");
    // R6: write in the middle cancels
    rd(P0, 1'b1); rd(P1, 1'b1); rd(P2, 1'b1); wr(P3); rd(P3, 1'b1); rd(P4, 1'b1);
    rd(R6, 1'b1); settle("R6");
    // R7: write starts in the cycle the sixth read ends
    prefix(5'b11111);
    addr = R6; idle(2);
    ce_n = 1'b0; idle(2);
    oe_n = 1'b0; idle(4);
    oe_n = 1'b1; we_n = 1'b0; idle(4);
    we_n = 1'b1; ce_n = 1'b1; idle(3);
    settle("R7");
    prefix(5'b00000); expect_cmd(1, "R7"); rd(S6, 1'b0); settle("R7");
    // R9: full recall sequence during store busy
    prefix(5'b00000); expect_cmd(1, "R9"); rd(S6, 1'b0);
    prefix(5'b00000); rd(R6, 1'b0); settle("R9");
    // R9: partial sequence during busy is not kept
    prefix(5'b00000); expect_cmd(1, "R9"); rd(S6, 1'b0);
    rd(P0, 1'b0); rd(P1, 1'b0); rd(P2, 1'b0);
    while (busy) @(negedge clk);
    rd(P3, 1'b0); rd(P4, 1'b0); rd(S6, 1'b0); settle("R9");

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 150000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule